// File: doc/BRIEF.md
# Fault-Aware Instruction Way Router

This block sits between a parallel fetch stage and a multi-way decode stage. Each accepted fetch group holds up to `NUM_WAYS` instructions in program order, and a valid bit marks each slot. A fault mask marks which decode ways must not be used. The router packs the valid instructions onto the healthy ways only, keeping program order. Each way has its own select multiplexer that picks the slot it receives. If a group has more valid instructions than there are healthy ways, the group is sent over several output beats, and fetch is held off until the last beat has been taken.

Both sides use a valid/ready handshake. The fault mask is captured when a group is accepted and is held until that group has been fully sent. If every way is marked faulty while the router is idle, a sticky error flag is raised and no further groups are taken until reset.

Top module: `fault_way_router`

## Requirements
- R1: After reset, with a fault mask that is not all ones, `in_ready` is 1, `out_valid` is 0, `out_way_vld` is 0 and `all_fault_err` is 0.
- R2: In every output beat, the oldest pending valid slot (slot 0 is the oldest; slot s sits at bits [32s+31:32s] of `in_insn`) goes to the lowest-numbered healthy way, the next oldest to the next healthy way, and so on. Input slots whose valid bit is 0 are skipped.
- R3: A way whose bit in the captured fault mask is 1 (1 = faulty) always shows `out_way_vld` = 0.
- R4: `out_way_slot` field w (bits [2w+1:2w]) carries the original slot index of the instruction on way w, and `out_way_insn` field w (bits [32w+31:32w]) carries that instruction.
- R5: When a group has more valid instructions than healthy ways, it is sent in consecutive beats of at most one instruction per healthy way, and `in_ready` stays 0 until the final beat.
- R6: `in_ready` is 1 in the cycle in which the final beat of a group is taken (`out_valid` and `out_ready` both 1), so a new group can be accepted in that same cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, in the next cycle `out_valid` stays 1 and all way outputs keep the same values.
- R8: The fault mask is sampled only when a group is accepted. A change to `fault_mask` while a group is being sent has no effect on that group's routing.
- R9: If `fault_mask` is all ones while no group is pending, `in_ready` is 0 at once and `all_fault_err` rises on the next clock edge. The flag then stays 1 and `in_ready` stays 0 until reset, whatever the mask does afterwards.
- R10: A group with no valid slots is accepted but produces no output beat, and `in_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A fetch group is presented |
| in_ready | output | 1 | Router can accept a group (low = stall fetch) |
| in_slot_vld | input | NUM_WAYS | Per-slot valid bits, slot 0 oldest |
| in_insn | input | NUM_WAYS*INSN_W | Instruction words of the group, slot s at field s |
| fault_mask | input | NUM_WAYS | 1 marks a faulty way |
| out_valid | output | 1 | An output beat is presented |
| out_ready | input | 1 | Decode accepts the current beat |
| out_way_vld | output | NUM_WAYS | Per-way valid bits of the beat |
| out_way_insn | output | NUM_WAYS*INSN_W | Per-way instruction word |
| out_way_slot | output | NUM_WAYS*clog2(NUM_WAYS) | Per-way original slot index |
| all_fault_err | output | 1 | Sticky flag: every way was marked faulty |

## Verification
Full groups on a clean mask check the plain pass-through. Groups with holes in the valid bits tell compaction apart from a fixed slot-to-way mapping. Masks with one to three faulty ways force splits into two, three and four beats, and these expose errors in how the remainder is carried across beats and in the stall timing. Randomly stalled `out_ready`, together with a mask that changes just after acceptance, separate a held assignment from one that re-reads live inputs. An all-faulty mask followed by a clean mask confirms that the error flag is sticky.

// File: rtl/frt_pkg.sv
package frt_pkg;

   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_SEND = 2'd1,
      RS_DEAD = 2'd2
   } rtr_state_e;

endpackage

// File: rtl/frt_prefix_rank.sv
module frt_prefix_rank #(
   parameter int NUM_BITS = 4,
   parameter int CNT_W    = 3
) (
   input  logic [NUM_BITS-1:0]       bits_i,
   output logic [NUM_BITS*CNT_W-1:0] rank_o,
   output logic [CNT_W-1:0]          total_o
);

   if ((1 << CNT_W) <= NUM_BITS) begin : g_bad_cnt
      $error("frt_prefix_rank: CNT_W too narrow for NUM_BITS");
   end

   // rank of bit i = number of set bits strictly below i
   always_comb begin
      logic [CNT_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < NUM_BITS; i++) begin
         rank_o[i*CNT_W +: CNT_W] = acc;
         acc = acc + CNT_W'(bits_i[i]);
      end
      total_o = acc;
   end

endmodule

// File: rtl/frt_way_mux.sv
module frt_way_mux #(
   parameter int NUM_WAYS = 4,
   parameter int INSN_W   = 32,
   parameter int IDX_W    = 2,
   parameter int CNT_W    = 3
) (
   input  logic                         busy_i,
   input  logic [NUM_WAYS-1:0]          healthy_i,
   input  logic [NUM_WAYS*CNT_W-1:0]    hrank_i,
   input  logic [NUM_WAYS-1:0]          pend_i,
   input  logic [NUM_WAYS*CNT_W-1:0]    prank_i,
   input  logic [NUM_WAYS*INSN_W-1:0]   insn_i,
   output logic [NUM_WAYS-1:0]          way_vld_o,
   output logic [NUM_WAYS*INSN_W-1:0]   way_insn_o,
   output logic [NUM_WAYS*IDX_W-1:0]    way_slot_o
);

   // one select mux per way: a way takes the pending slot whose pending
   // rank equals the way's rank among healthy ways
   for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
      logic [IDX_W-1:0] sel;
      logic             hit;

      always_comb begin
         sel = '0;
         hit = 1'b0;
         for (int s = 0; s < NUM_WAYS; s++) begin
            if (pend_i[s] && (prank_i[s*CNT_W +: CNT_W] == hrank_i[g*CNT_W +: CNT_W])) begin
               sel = IDX_W'(s);
               hit = 1'b1;
            end
         end
      end

      assign way_vld_o[g]                    = busy_i & healthy_i[g] & hit;
      assign way_insn_o[g*INSN_W +: INSN_W]  = insn_i[int'(sel)*INSN_W +: INSN_W];
      assign way_slot_o[g*IDX_W +: IDX_W]    = sel;
   end

endmodule

// File: rtl/frt_group_ctrl.sv
module frt_group_ctrl
   import frt_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int INSN_W   = 32,
   parameter int CNT_W    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [NUM_WAYS-1:0]          in_slot_vld,
   input  logic [NUM_WAYS*INSN_W-1:0]   in_insn,
   input  logic [NUM_WAYS-1:0]          fault_mask,
   input  logic                         out_ready,
   input  logic [NUM_WAYS*CNT_W-1:0]    prank_i,
   input  logic [CNT_W-1:0]             ptotal_i,
   input  logic [CNT_W-1:0]             htotal_i,
   output logic                         in_ready,
   output logic                         busy_o,
   output logic [NUM_WAYS-1:0]          pend_o,
   output logic [NUM_WAYS-1:0]          mask_o,
   output logic [NUM_WAYS*INSN_W-1:0]   insn_o,
   output logic                         err_o
);

   rtr_state_e                  state_q, state_d;
   logic [NUM_WAYS-1:0]         pend_q, pend_d, sent;
   logic [NUM_WAYS-1:0]         mask_q;
   logic [NUM_WAYS*INSN_W-1:0]  insn_q;
   logic                        all_bad, final_beat, accept, busy;

   assign busy       = (state_q == RS_SEND);
   assign all_bad    = &fault_mask;
   assign final_beat = busy && (ptotal_i <= htotal_i);
   assign in_ready   = (state_q != RS_DEAD) && !all_bad && (!busy || (out_ready && final_beat));
   assign accept     = in_valid && in_ready;

   // slots taken by the current beat: the first htotal pending slots
   always_comb begin
      for (int s = 0; s < NUM_WAYS; s++) begin
         sent[s] = pend_q[s] && (prank_i[s*CNT_W +: CNT_W] < htotal_i);
      end
   end

   always_comb begin
      pend_d = pend_q;
      if (busy && out_ready) pend_d = pend_q & ~sent;
      if (accept)            pend_d = in_slot_vld;
      if (state_q == RS_DEAD)
         state_d = RS_DEAD;
      else if (!busy && all_bad)
         state_d = RS_DEAD;
      else if (|pend_d)
         state_d = RS_SEND;
      else
         state_d = RS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         pend_q  <= '0;
         mask_q  <= '0;
         insn_q  <= '0;
      end else begin
         state_q <= state_d;
         pend_q  <= (state_d == RS_DEAD) ? '0 : pend_d;
         if (accept) begin
            mask_q <= fault_mask;
            insn_q <= in_insn;
         end
      end
   end

   assign busy_o = busy;
   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign insn_o = insn_q;
   assign err_o  = (state_q == RS_DEAD);

   AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o);                 // R9
   AST_DEAD_CLOSED:  assert property (@(posedge clk) disable iff (!rst_n) err_o |-> !in_ready);             // R9
   AST_BUSY_STALL:   assert property (@(posedge clk) disable iff (!rst_n) (busy && !out_ready) |-> !in_ready); // R5
   AST_MASK_FROZEN:  assert property (@(posedge clk) disable iff (!rst_n) (busy && !accept) |=> $stable(mask_q)); // R8

endmodule

// File: rtl/fault_way_router.sv
module fault_way_router
   import frt_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int INSN_W   = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   output logic                                  in_ready,
   input  logic [NUM_WAYS-1:0]                   in_slot_vld,
   input  logic [NUM_WAYS*INSN_W-1:0]            in_insn,
   input  logic [NUM_WAYS-1:0]                   fault_mask,
   output logic                                  out_valid,
   input  logic                                  out_ready,
   output logic [NUM_WAYS-1:0]                   out_way_vld,
   output logic [NUM_WAYS*INSN_W-1:0]            out_way_insn,
   output logic [NUM_WAYS*$clog2(NUM_WAYS)-1:0]  out_way_slot,
   output logic                                  all_fault_err
);

   localparam int IDX_W = $clog2(NUM_WAYS);
   localparam int CNT_W = $clog2(NUM_WAYS + 1);

   if (NUM_WAYS < 2) begin : g_bad_ways
      $error("fault_way_router: NUM_WAYS must be at least 2");
   end
   if (INSN_W < 1) begin : g_bad_width
      $error("fault_way_router: INSN_W must be at least 1");
   end

   logic                        busy;
   logic [NUM_WAYS-1:0]         pend, mask_q, healthy;
   logic [NUM_WAYS*INSN_W-1:0]  insn_q;
   logic [NUM_WAYS*CNT_W-1:0]   prank, hrank;
   logic [CNT_W-1:0]            ptotal, htotal;

   assign healthy = ~mask_q;

   frt_prefix_rank #(.NUM_BITS(NUM_WAYS), .CNT_W(CNT_W)) i_pend_rank (
      .bits_i (pend),
      .rank_o (prank),
      .total_o(ptotal)
   );

   frt_prefix_rank #(.NUM_BITS(NUM_WAYS), .CNT_W(CNT_W)) i_way_rank (
      .bits_i (healthy),
      .rank_o (hrank),
      .total_o(htotal)
   );

   frt_group_ctrl #(.NUM_WAYS(NUM_WAYS), .INSN_W(INSN_W), .CNT_W(CNT_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_slot_vld(in_slot_vld),
      .in_insn    (in_insn),
      .fault_mask (fault_mask),
      .out_ready  (out_ready),
      .prank_i    (prank),
      .ptotal_i   (ptotal),
      .htotal_i   (htotal),
      .in_ready   (in_ready),
      .busy_o     (busy),
      .pend_o     (pend),
      .mask_o     (mask_q),
      .insn_o     (insn_q),
      .err_o      (all_fault_err)
   );

   frt_way_mux #(.NUM_WAYS(NUM_WAYS), .INSN_W(INSN_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_mux (
      .busy_i    (busy),
      .healthy_i (healthy),
      .hrank_i   (hrank),
      .pend_i    (pend),
      .prank_i   (prank),
      .insn_i    (insn_q),
      .way_vld_o (out_way_vld),
      .way_insn_o(out_way_insn),
      .way_slot_o(out_way_slot)
   );

   assign out_valid = busy;

   // order check: slot indices rise with way number, and no healthy way
   // is skipped below an occupied one
   logic order_ok;
   always_comb begin
      logic             seen, gap;
      logic [IDX_W-1:0] last_slot;
      order_ok  = 1'b1;
      seen      = 1'b0;
      gap       = 1'b0;
      last_slot = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (out_way_vld[w]) begin
            if (gap) order_ok = 1'b0;
            if (seen && (out_way_slot[w*IDX_W +: IDX_W] <= last_slot)) order_ok = 1'b0;
            seen      = 1'b1;
            last_slot = out_way_slot[w*IDX_W +: IDX_W];
         end else if (healthy[w]) begin
            gap = 1'b1;
         end
      end
   end

   AST_FAULTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (out_way_vld & mask_q) == '0);  // R3
   AST_PROGRAM_ORDER: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> order_ok);       // R2
   AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_way_vld) && $stable(out_way_insn) && $stable(out_way_slot))); // R7
   AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (out_way_vld == '0)); // R1

endmodule

// File: tb/test_fault_way_router.sv
`timescale 1ns/1ps
module test_fault_way_router;

   localparam int N = 4;
   localparam int W = 32;

   typedef struct packed {
      logic         last;
      logic [3:0]   mask;
      logic [3:0]   vld;
      logic [127:0] insn;
      logic [7:0]   slot;
   } beat_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [3:0]   in_slot_vld = '0;
   logic [127:0] in_insn = '0;
   logic [3:0]   fault_mask = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [3:0]   out_way_vld;
   logic [127:0] out_way_insn;
   logic [7:0]   out_way_slot;
   logic         all_fault_err;

   int  total = 0;
   int  bad = 0;
   bit  rnd_rdy = 1'b0;
   bit  mon_on = 1'b0;
   bit  finished = 1'b0;
   beat_t q[$];

   always #2.5 clk = ~clk;

   fault_way_router #(.NUM_WAYS(N), .INSN_W(W)) i_fault_way_router (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_slot_vld(in_slot_vld), .in_insn(in_insn), .fault_mask(fault_mask),
      .out_valid(out_valid), .out_ready(out_ready), .out_way_vld(out_way_vld),
      .out_way_insn(out_way_insn), .out_way_slot(out_way_slot),
      .all_fault_err(all_fault_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected beats of one group from the requirements (R2 R4 R5)
   task automatic model(input logic [3:0] vld, input logic [127:0] data, input logic [3:0] mask);
      int hw[4];
      int ps[4];
      int hn, pn, idx;
      beat_t b;
      hn = 0; pn = 0; idx = 0;
      for (int w = 0; w < 4; w++) if (!mask[w]) begin hw[hn] = w; hn++; end
      for (int s = 0; s < 4; s++) if (vld[s])   begin ps[pn] = s; pn++; end
      while (idx < pn) begin
         b = '0;
         b.mask = mask;
         for (int k = 0; k < hn; k++) begin
            if (idx < pn) begin
               b.vld[hw[k]] = 1'b1;
               b.insn[hw[k]*32 +: 32] = data[ps[idx]*32 +: 32];
               b.slot[hw[k]*2 +: 2] = 2'(ps[idx]);
               idx++;
            end
         end
         b.last = (idx >= pn);
         q.push_back(b);
      end
   endtask

   // driver: called at a falling edge, returns at a falling edge
   task automatic send(input logic [3:0] vld, input logic [127:0] data, input logic [3:0] mask);
      in_slot_vld = vld;
      in_insn     = data;
      fault_mask  = mask;
      in_valid    = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      model(vld, data, mask);
      @(negedge clk);
      in_valid   = 1'b0;
      fault_mask = 4'b0000;   // live mask changes right after acceptance (R8)
   endtask

   task automatic drain();
      int n;
      n = 0;
      do begin @(negedge clk); #1; n++; end while ((q.size() != 0 || out_valid) && n < 200);
      chk(q.size() == 0, "R5 drain queue empty", 128'(q.size()), 128'd0);
   endtask

   always @(negedge clk) out_ready <= rnd_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;

   // monitor / scoreboard
   logic         prev_stall = 1'b0;
   logic [3:0]   prev_vld;
   logic [127:0] prev_insn;
   logic [7:0]   prev_slot;
   always begin
      @(negedge clk); #1;
      if (mon_on) begin
         if (prev_stall) begin
            chk(out_valid && out_way_vld == prev_vld && out_way_insn == prev_insn && out_way_slot == prev_slot,
                "R7 outputs held under back-pressure", {out_way_vld, out_way_slot}, {prev_vld, prev_slot});
         end
         if (out_valid && !out_ready) chk(!in_ready, "R5 stall during pending beat", 128'(in_ready), 128'd0);
         if (out_valid && out_ready) begin
            if (q.size() == 0) begin
               chk(1'b0, "R10 unexpected beat", 128'(out_way_vld), 128'd0);
            end else begin
               beat_t b;
               b = q.pop_front();
               chk(out_way_vld == b.vld, "R2/R8 way occupancy", 128'(out_way_vld), 128'(b.vld));
               chk((out_way_vld & b.mask) == 4'b0, "R3 faulty way quiet", 128'(out_way_vld), 128'(b.vld));
               for (int w = 0; w < 4; w++) begin
                  if (b.vld[w]) begin
                     chk(out_way_insn[w*32 +: 32] == b.insn[w*32 +: 32], "R4 way instruction",
                         128'(out_way_insn[w*32 +: 32]), 128'(b.insn[w*32 +: 32]));
                     chk(out_way_slot[w*2 +: 2] == b.slot[w*2 +: 2], "R4 way slot index",
                         128'(out_way_slot[w*2 +: 2]), 128'(b.slot[w*2 +: 2]));
                  end
               end
               if (b.last) chk(in_ready, "R6 ready on final beat", 128'(in_ready), 128'd1);
               else        chk(!in_ready, "R5 fetch stalled mid-group", 128'(in_ready), 128'd0);
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_vld   = out_way_vld;
         prev_insn  = out_way_insn;
         prev_slot  = out_way_slot;
      end
   end

   function automatic logic [127:0] rnd_group();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(in_ready == 1'b1, "R1 reset in_ready", 128'(in_ready), 128'd1);
      chk(out_valid == 1'b0, "R1 reset out_valid", 128'(out_valid), 128'd0);
      chk(out_way_vld == 4'b0, "R1 reset way valid", 128'(out_way_vld), 128'd0);
      chk(all_fault_err == 1'b0, "R1 reset error flag", 128'(all_fault_err), 128'd0);
      mon_on = 1'b1;
      @(negedge clk);

      // clean mask, full group: single beat (R2)
      send(4'b1111, rnd_group(), 4'b0000);
      drain();
      // two faulty ways: two beats (R5)
      send(4'b1111, rnd_group(), 4'b0101);
      drain();
      // one healthy way, holes in slots: three beats (R2 R5)
      send(4'b1011, rnd_group(), 4'b1110);
      drain();
      // compaction of a middle pair onto ways 0,1 (R2 R4)
      send(4'b0110, rnd_group(), 4'b0000);
      drain();
      // empty group (R10)
      send(4'b0000, rnd_group(), 4'b0000);
      #1;
      chk(!out_valid, "R10 empty group no beat", 128'(out_valid), 128'd0);
      chk(in_ready, "R10 ready after empty group", 128'(in_ready), 128'd1);
      @(negedge clk); #1;
      chk(!out_valid, "R10 empty group still no beat", 128'(out_valid), 128'd0);

      // back-to-back groups with back-pressure and mask changes (R6 R7 R8)
      rnd_rdy = 1'b1;
      send(4'b1111, rnd_group(), 4'b1001);
      send(4'b1101, rnd_group(), 4'b0111);
      send(4'b1111, rnd_group(), 4'b1011);
      for (int i = 0; i < 60; i++) begin
         logic [3:0] m;
         m = 4'($urandom_range(0, 14));
         send(4'($urandom_range(0, 15)), rnd_group(), m);
      end
      drain();
      rnd_rdy = 1'b0;
      @(negedge clk);

      // all-faulty mask while idle (R9)
      fault_mask = 4'b1111;
      #1;
      chk(!in_ready, "R9 ready drops on all-faulty mask", 128'(in_ready), 128'd0);
      @(negedge clk); #1;
      chk(all_fault_err, "R9 error flag raised", 128'(all_fault_err), 128'd1);
      fault_mask  = 4'b0000;
      in_slot_vld = 4'b1111;
      in_valid    = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk(all_fault_err && !in_ready && !out_valid, "R9 sticky error, no accept",
             {125'd0, all_fault_err, in_ready, out_valid}, 128'd4);
      end
      in_valid = 1'b0;

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule